// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block selects the operands for the instruction in the execute stage of a five-stage in-order pipeline. It compares the two source register indices of that instruction with the destination indices carried by the two younger pipeline registers: the one between execute and memory, and the one between memory and writeback. For each ALU input it then picks one of three values: the register-file read, the ALU result waiting in the memory stage, or the value about to be written back. With this choice, chains of dependent ALU instructions run back to back without stalling.

A second, smaller path serves the data-memory write port. When a load sits in writeback and the instruction in the memory stage is a store of the same register, the loaded value goes straight to the store data. A memory-to-memory copy then needs no bubble. The block is purely combinational. It contains the operand multiplexers so that it can be placed and tested as one piece. The register file, ALU, pipeline registers and the load-use stall are not part of it.

Top module: `opb_bypass_unit`

## Requirements
- R1: When neither younger stage supplies an operand's source register, that operand's select is 2'b00 and the operand equals its register-file value.
- R2: When the memory stage has write enable set and a nonzero destination equal to an operand's source index, that operand's select is 2'b10 and the operand equals the memory-stage result.
- R3: When the memory stage does not supply the operand, and the writeback stage has write enable set and a nonzero destination equal to the source index, the select is 2'b01 and the operand equals the writeback data.
- R4: When both younger stages supply the same source register, the memory stage wins (select 2'b10).
- R5: Register index 0 is never forwarded from either stage, whatever the enables are.
- R6: A stage whose write enable is low is never forwarded from, even if its destination index matches.
- R7: The two operands are resolved independently and may take different sources in the same cycle.
- R8: When writeback holds a load with write enable set, the memory stage holds a store, and the store's data index equals the load's nonzero destination, the store select is 1 and the store data equals the writeback data.
- R9: In every other case the store select is 0 and the store data equals the store's register-read value.
- R10: The sequence r1=r1+r2, r1=r1+r3, r1=r1+r4 gives the third addition the result of the second addition as its first operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | AW | First source register index of the execute-stage instruction |
| ex_src_b_idx | input | AW | Second source register index of the execute-stage instruction |
| ex_rf_a | input | DW | Register-file value read for the first source |
| ex_rf_b | input | DW | Register-file value read for the second source |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst_idx | input | AW | Memory-stage destination register index |
| mem_result | input | DW | ALU result held in the memory stage |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_src_idx | input | AW | Register index supplying the store data |
| mem_st_rf_data | input | DW | Store data as read from the register file |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_dst_idx | input | AW | Writeback-stage destination register index |
| wb_data | input | DW | Value being written back |
| wb_is_load | input | 1 | Writeback-stage instruction is a load |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| alu_op_a | output | DW | First ALU operand after bypass |
| alu_op_b | output | DW | Second ALU operand after bypass |
| st_sel | output | 1 | Store data taken from writeback |
| st_wdata | output | DW | Data presented to the data-memory write port |

## Verification
The bench targets the double match, where both younger stages write the register being read. A design that preferred writeback there would hand the add chain a stale value, so its final sum would come out short. It drives register 0 as destination with every enable set; forwarding it would make writes to the hardwired zero visible. It also turns off the enables while the indices match, and it breaks each of the four store-bypass conditions in turn, so that a bypass that ignores the load type or the store flag would corrupt the memory write data. A randomized sweep over a narrow index range compares every select and data output against a model written from the requirements.

// File: rtl/opb_pkg.sv
package opb_pkg;
   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10
   } src_sel_e;
endpackage

// File: rtl/opb_src_pick.sv
module opb_src_pick
   import opb_pkg::*;
#(
   parameter int AW = 5,
   parameter bit ZERO_HARDWIRED = 1'b1
) (
   input  logic [AW-1:0] src_idx,
   input  logic          mem_we,
   input  logic [AW-1:0] mem_dst,
   input  logic          wb_we,
   input  logic [AW-1:0] wb_dst,
   output src_sel_e      sel
);
   localparam logic [AW-1:0] ZERO_IDX = '0;

   logic mem_live, wb_live;
   logic mem_hit, wb_hit;

   generate
      if (ZERO_HARDWIRED) begin : g_zero_guard
         assign mem_live = mem_we && (mem_dst != ZERO_IDX);
         assign wb_live  = wb_we  && (wb_dst  != ZERO_IDX);
      end else begin : g_no_zero_guard
         assign mem_live = mem_we;
         assign wb_live  = wb_we;
      end
   endgenerate

   assign mem_hit = mem_live && (mem_dst == src_idx);
   assign wb_hit  = wb_live  && (wb_dst  == src_idx);

   always_comb begin
      if (mem_hit)     sel = SRC_MEM;
      else if (wb_hit) sel = SRC_WB;
      else             sel = SRC_RF;
   end

   always_comb begin
      if (!$isunknown({src_idx, mem_we, mem_dst, wb_we, wb_dst})) begin
         // R5 with R6: nothing is forwarded from a disabled stage or from index 0
         p_no_fwd_idle_r6: assert (!(sel == SRC_MEM && !mem_we) && !(sel == SRC_WB && !wb_we))
            else $error("forward from disabled stage");
         p_zero_quiet_r5: assert (!(ZERO_HARDWIRED && src_idx == ZERO_IDX) || sel == SRC_RF)
            else $error("index zero forwarded");
         p_mem_first_r4: assert (!(sel == SRC_WB && mem_we && mem_dst == src_idx && mem_dst != ZERO_IDX))
            else $error("writeback chosen over memory stage");
      end
   end
endmodule

// File: rtl/opb_mux.sv
module opb_mux
   import opb_pkg::*;
#(
   parameter int DW = 32
) (
   input  src_sel_e       sel,
   input  logic [DW-1:0]  rf_val,
   input  logic [DW-1:0]  mem_val,
   input  logic [DW-1:0]  wb_val,
   output logic [DW-1:0]  y
);
   always_comb begin
      unique case (sel)
         SRC_MEM: y = mem_val;
         SRC_WB:  y = wb_val;
         default: y = rf_val;
      endcase
   end

   always_comb begin
      if (!$isunknown({sel, rf_val, mem_val, wb_val})) begin
         p_rf_path_r1: assert (sel != SRC_RF || y == rf_val)
            else $error("register path not passed");
         p_mem_path_r2: assert (sel != SRC_MEM || y == mem_val)
            else $error("memory path not passed");
         p_wb_path_r3: assert (sel != SRC_WB || y == wb_val)
            else $error("writeback path not passed");
      end
   end
endmodule

// File: rtl/opb_store_pick.sv
module opb_store_pick #(
   parameter int AW = 5,
   parameter int DW = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic          mem_is_store,
   input  logic [AW-1:0] st_src_idx,
   input  logic [DW-1:0] st_rf_data,
   input  logic          wb_we,
   input  logic          wb_is_load,
   input  logic [AW-1:0] wb_dst,
   input  logic [DW-1:0] wb_val,
   output logic          st_sel,
   output logic [DW-1:0] st_wdata
);
   localparam logic [AW-1:0] ZERO_IDX = '0;

   generate
      if (ENABLE) begin : g_bypass
         assign st_sel = mem_is_store && wb_we && wb_is_load &&
                         (wb_dst != ZERO_IDX) && (wb_dst == st_src_idx);
      end else begin : g_plain
         assign st_sel = 1'b0;
      end
   endgenerate

   assign st_wdata = st_sel ? wb_val : st_rf_data;

   always_comb begin
      if (!$isunknown({mem_is_store, st_src_idx, wb_we, wb_is_load, wb_dst})) begin
         p_store_gate_r9: assert (!st_sel || (mem_is_store && wb_is_load && wb_we))
            else $error("store bypass without load/store pair");
         p_store_zero_r8: assert (!st_sel || st_src_idx != ZERO_IDX)
            else $error("store bypass of index zero");
      end
   end
endmodule

// File: rtl/opb_bypass_unit.sv
module opb_bypass_unit
   import opb_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 32,
   parameter bit ZERO_HARDWIRED = 1'b1,
   parameter bit STORE_BYPASS = 1'b1
) (
   input  logic [AW-1:0] ex_src_a_idx,
   input  logic [AW-1:0] ex_src_b_idx,
   input  logic [DW-1:0] ex_rf_a,
   input  logic [DW-1:0] ex_rf_b,
   input  logic          mem_wr_en,
   input  logic [AW-1:0] mem_dst_idx,
   input  logic [DW-1:0] mem_result,
   input  logic          mem_is_store,
   input  logic [AW-1:0] mem_st_src_idx,
   input  logic [DW-1:0] mem_st_rf_data,
   input  logic          wb_wr_en,
   input  logic [AW-1:0] wb_dst_idx,
   input  logic [DW-1:0] wb_data,
   input  logic          wb_is_load,
   output logic [1:0]    sel_a,
   output logic [1:0]    sel_b,
   output logic [DW-1:0] alu_op_a,
   output logic [DW-1:0] alu_op_b,
   output logic          st_sel,
   output logic [DW-1:0] st_wdata
);
   localparam int N_OPND = 2;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("AW must lie in 1..8");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic [AW-1:0] src_idx [N_OPND];
   logic [DW-1:0] rf_val  [N_OPND];
   src_sel_e      sel     [N_OPND];
   logic [DW-1:0] opnd    [N_OPND];

   assign src_idx[0] = ex_src_a_idx;
   assign src_idx[1] = ex_src_b_idx;
   assign rf_val[0]  = ex_rf_a;
   assign rf_val[1]  = ex_rf_b;

   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
         opb_src_pick #(.AW(AW), .ZERO_HARDWIRED(ZERO_HARDWIRED)) u_pick (
            .src_idx (src_idx[g]),
            .mem_we  (mem_wr_en),
            .mem_dst (mem_dst_idx),
            .wb_we   (wb_wr_en),
            .wb_dst  (wb_dst_idx),
            .sel     (sel[g])
         );
         opb_mux #(.DW(DW)) u_mux (
            .sel     (sel[g]),
            .rf_val  (rf_val[g]),
            .mem_val (mem_result),
            .wb_val  (wb_data),
            .y       (opnd[g])
         );
      end
   endgenerate

   assign sel_a    = sel[0];
   assign sel_b    = sel[1];
   assign alu_op_a = opnd[0];
   assign alu_op_b = opnd[1];

   opb_store_pick #(.AW(AW), .DW(DW), .ENABLE(STORE_BYPASS)) u_store (
      .mem_is_store (mem_is_store),
      .st_src_idx   (mem_st_src_idx),
      .st_rf_data   (mem_st_rf_data),
      .wb_we        (wb_wr_en),
      .wb_is_load   (wb_is_load),
      .wb_dst       (wb_dst_idx),
      .wb_val       (wb_data),
      .st_sel       (st_sel),
      .st_wdata     (st_wdata)
   );

   always_comb begin
      if (!$isunknown({sel_a, sel_b})) begin
         p_sel_legal_r7: assert (sel_a != 2'b11 && sel_b != 2'b11)
            else $error("illegal select code");
      end
   end
endmodule

// File: tb/opb_bypass_unit_tb.sv
module opb_bypass_unit_tb;
   localparam int AW = 5;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [AW-1:0] ex_src_a_idx, ex_src_b_idx, mem_dst_idx, mem_st_src_idx, wb_dst_idx;
   logic [DW-1:0] ex_rf_a, ex_rf_b, mem_result, mem_st_rf_data, wb_data;
   logic mem_wr_en, mem_is_store, wb_wr_en, wb_is_load;
   logic [1:0] sel_a, sel_b;
   logic [DW-1:0] alu_op_a, alu_op_b, st_wdata;
   logic st_sel;

   int total = 0;
   int bad = 0;
   bit done = 0;

   opb_bypass_unit #(.AW(AW), .DW(DW)) u_dut (.*);

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      @(negedge clk);
      ex_src_a_idx = 0; ex_src_b_idx = 0; mem_dst_idx = 0; mem_st_src_idx = 0; wb_dst_idx = 0;
      ex_rf_a = 32'hA0A0_0001; ex_rf_b = 32'hB0B0_0002; mem_result = 32'hCCCC_0003;
      mem_st_rf_data = 32'h5555_0004; wb_data = 32'hDDDD_0005;
      mem_wr_en = 0; mem_is_store = 0; wb_wr_en = 0; wb_is_load = 0;
   endtask

   task automatic settle();
      #3;
   endtask

   task automatic t_idle();
      clear_inputs(); ex_src_a_idx = 3; ex_src_b_idx = 4; mem_dst_idx = 5; wb_dst_idx = 6;
      mem_wr_en = 1; wb_wr_en = 1; settle();
      chk("R1 sel_a", sel_a, 0); chk("R1 sel_b", sel_b, 0);
      chk("R1 op_a", alu_op_a, ex_rf_a); chk("R1 op_b", alu_op_b, ex_rf_b);
      chk("R9 idle st_sel", st_sel, 0); chk("R9 idle st_wdata", st_wdata, mem_st_rf_data);
   endtask

   task automatic t_mem_hit();
      clear_inputs(); ex_src_a_idx = 7; mem_dst_idx = 7; mem_wr_en = 1; settle();
      chk("R2 sel_a", sel_a, 2'b10); chk("R2 op_a", alu_op_a, mem_result);
      chk("R1 sel_b untouched", sel_b, 0);
   endtask

   task automatic t_wb_hit();
      clear_inputs(); ex_src_b_idx = 9; wb_dst_idx = 9; wb_wr_en = 1;
      mem_dst_idx = 10; mem_wr_en = 1; settle();
      chk("R3 sel_b", sel_b, 2'b01); chk("R3 op_b", alu_op_b, wb_data);
   endtask

   task automatic t_double();
      clear_inputs(); ex_src_a_idx = 12; ex_src_b_idx = 12;
      mem_dst_idx = 12; wb_dst_idx = 12; mem_wr_en = 1; wb_wr_en = 1; settle();
      chk("R4 sel_a", sel_a, 2'b10); chk("R4 sel_b", sel_b, 2'b10);
      chk("R4 op_a", alu_op_a, mem_result);
   endtask

   task automatic t_zero();
      clear_inputs(); mem_wr_en = 1; wb_wr_en = 1; settle();
      chk("R5 sel_a", sel_a, 0); chk("R5 sel_b", sel_b, 0);
      chk("R5 op_a", alu_op_a, ex_rf_a);
      mem_dst_idx = 1; settle();
      chk("R5 wb zero", sel_a, 0);
   endtask

   task automatic t_disabled();
      clear_inputs(); ex_src_a_idx = 14; ex_src_b_idx = 14; mem_dst_idx = 14; wb_dst_idx = 14;
      settle();
      chk("R6 sel_a", sel_a, 0); chk("R6 op_b", alu_op_b, ex_rf_b);
      wb_wr_en = 1; settle();
      chk("R6 mem off wb on", sel_a, 2'b01);
   endtask

   task automatic t_split();
      clear_inputs(); ex_src_a_idx = 2; ex_src_b_idx = 3; mem_dst_idx = 3; wb_dst_idx = 2;
      mem_wr_en = 1; wb_wr_en = 1; settle();
      chk("R7 sel_a", sel_a, 2'b01); chk("R7 sel_b", sel_b, 2'b10);
      chk("R7 op_a", alu_op_a, wb_data); chk("R7 op_b", alu_op_b, mem_result);
   endtask

   task automatic t_chain();
      logic [DW-1:0] sum;
      clear_inputs();
      // r1=10, r2=3, r3=5, r4=7: first add gave 13 (now writeback), second 18 (now memory)
      ex_src_a_idx = 1; ex_src_b_idx = 4; ex_rf_a = 10; ex_rf_b = 7;
      mem_dst_idx = 1; mem_result = 18; mem_wr_en = 1;
      wb_dst_idx = 1; wb_data = 13; wb_wr_en = 1; settle();
      sum = alu_op_a + alu_op_b;
      chk("R10 chain sum", sum, 25);
   endtask

   task automatic t_store();
      clear_inputs(); mem_is_store = 1; mem_st_src_idx = 8; wb_dst_idx = 8;
      wb_wr_en = 1; wb_is_load = 1; settle();
      chk("R8 st_sel", st_sel, 1); chk("R8 st_wdata", st_wdata, wb_data);
      wb_is_load = 0; settle();
      chk("R9 not load", st_wdata, mem_st_rf_data);
      wb_is_load = 1; mem_is_store = 0; settle();
      chk("R9 not store", st_sel, 0);
      mem_is_store = 1; wb_wr_en = 0; settle();
      chk("R9 no write", st_sel, 0);
      wb_wr_en = 1; mem_st_src_idx = 9; settle();
      chk("R9 idx differ", st_sel, 0);
      mem_st_src_idx = 0; wb_dst_idx = 0; settle();
      chk("R9 idx zero", st_wdata, mem_st_rf_data);
   endtask

   function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
      if (mem_wr_en && mem_dst_idx != 0 && mem_dst_idx == s) return 2'b10;
      if (wb_wr_en && wb_dst_idx != 0 && wb_dst_idx == s) return 2'b01;
      return 2'b00;
   endfunction

   task automatic t_random();
      logic [1:0] ea, eb;
      logic es;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         ex_src_a_idx = AW'($urandom_range(0, 3)); ex_src_b_idx = AW'($urandom_range(0, 3));
         mem_dst_idx = AW'($urandom_range(0, 3)); wb_dst_idx = AW'($urandom_range(0, 3));
         mem_st_src_idx = AW'($urandom_range(0, 3));
         mem_wr_en = 1'($urandom); wb_wr_en = 1'($urandom);
         mem_is_store = 1'($urandom); wb_is_load = 1'($urandom);
         ex_rf_a = $urandom; ex_rf_b = $urandom; mem_result = $urandom;
         wb_data = $urandom; mem_st_rf_data = $urandom;
         settle();
         ea = ref_sel(ex_src_a_idx); eb = ref_sel(ex_src_b_idx);
         es = mem_is_store && wb_is_load && wb_wr_en && wb_dst_idx != 0 && wb_dst_idx == mem_st_src_idx;
         chk("R2 R3 R4 rand sel_a", sel_a, ea);
         chk("R7 rand sel_b", sel_b, eb);
         chk("R1 rand op_a", alu_op_a, ea == 2'b10 ? mem_result : ea == 2'b01 ? wb_data : ex_rf_a);
         chk("R5 rand op_b", alu_op_b, eb == 2'b10 ? mem_result : eb == 2'b01 ? wb_data : ex_rf_b);
         chk("R8 rand st_wdata", st_wdata, es ? wb_data : mem_st_rf_data);
      end
   endtask

   initial begin
      clear_inputs();
      t_idle(); t_mem_hit(); t_wb_hit(); t_double(); t_zero(); t_disabled();
      t_split(); t_chain(); t_store(); t_random();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (50000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule